// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a synchronous DRAM bus and turns each clock's pin state into one command code. The pins it takes are clock enable, chip select, the three strobes, the bank select and the auto-precharge address bit. It keeps a record of which of the banks hold an open row, and it raises a one-cycle error pulse with a reason code when the command stream breaks the bank protocol. It only observes the bus and never drives it.

A controller's verification environment or a debug monitor places it on the command bus. Every output is registered. The command seen at rising edge k is reported on `cmd_o`, the bank state that results from it shows on `bank_open_o`, and any error it caused is on `err_o` and `err_code_o`. All of these are valid just after edge k and stay until the next edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: While reset is held, and after it, until the first command is sampled, `cmd_o` is 0 (deselect), `bank_open_o` is all zero, `err_o` is 0 and `err_code_o` is 0.
- R2: With clock enable high on the previous and current edge and chip select high, the code is 0 (deselect), whatever the strobes are. No bank changes state and no error is raised.
- R3: With chip select low and clock enable high on the previous edge, the strobes {ras_n,cas_n,we_n} decode as follows. 111 gives NOP (1) and 000 gives mode set (2). 011 gives activate (3) and 101 gives read (4). 100 gives write (5) and 110 gives burst stop (8).
- R4: An activate marks the bank selected by `ba` as open. Bit b of `bank_open_o` is bank b.
- R5: The strobe pattern 010 precharges. With `a10` low it gives code 6 and closes only the addressed bank. With `a10` high it gives code 7 and closes every bank.
- R6: The pattern 001 gives auto refresh (9) when clock enable is high on both edges. It gives self-refresh entry (10) when clock enable was high on the previous edge and is low now. If clock enable was low on the previous edge, the code is 11 (clock held), and the pins change no state and raise no error.
- R7: A read or a write to a bank with no open row gives error code 1.
- R8: An activate to a bank that is already open gives error code 2, and the bank stays open.
- R9: An activate to a different bank than the previous activate gives error code 3 when it comes fewer than TRRD edges after that activate. At exactly TRRD edges it raises no error.
- R10: An auto refresh or a self-refresh entry while any bank is open gives error code 4. A mode set while any bank is open gives error code 5.
- R11: `err_o` is high only in the cycle after an offending command. In every other cycle `err_code_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples the pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| a10 | input | 1 | Auto-precharge / all-bank address bit |
| cmd_o | output | 4 | Decoded command code of the last sampled edge |
| bank_open_o | output | NUM_BANKS | Open-row flag per bank |
| err_o | output | 1 | Protocol error pulse |
| err_code_o | output | 3 | Reason for the error, 0 when none |

## Verification
The bench builds the block with four banks and TRRD set to 3 rather than the default of 2. A spacing of one edge between activates to different banks is then an error. A spacing of exactly three edges is legal. This exercises both sides of the delay window and shows that the counter saturates instead of wrapping. With four banks, precharging one bank can be checked against its neighbours while others stay open, next to the all-bank precharge.

// File: rtl/sdcm_pkg.sv
// Shared command and error encodings for the SDRAM command monitor.
// Assumes a 4-bit command code and a 3-bit error code on the outputs.
package sdcm_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL  = 4'd0,
        CMD_NOP    = 4'd1,
        CMD_MODE   = 4'd2,
        CMD_ACT    = 4'd3,
        CMD_READ   = 4'd4,
        CMD_WRITE  = 4'd5,
        CMD_PRE    = 4'd6,
        CMD_PREALL = 4'd7,
        CMD_BSTOP  = 4'd8,
        CMD_AREF   = 4'd9,
        CMD_SREF   = 4'd10,
        CMD_HOLD   = 4'd11
    } sdcm_cmd_e;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_IDLE_BANK  = 3'd1,
        ERR_REOPEN     = 3'd2,
        ERR_ACT_SPACE  = 3'd3,
        ERR_REF_OPEN   = 3'd4,
        ERR_MODE_OPEN  = 3'd5
    } sdcm_err_e;

endpackage

// File: rtl/sdcm_decode.sv
// Pin-level command decoder.
// Turns the sampled control pins into one command code. The clock-enable
// value of the previous edge is kept here: when it was low, no command is
// taken from the pins. Assumes the pins are stable around the rising edge.
module sdcm_decode
    import sdcm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cke,
    input  logic      cs_n,
    input  logic      ras_n,
    input  logic      cas_n,
    input  logic      we_n,
    input  logic      a10,
    output sdcm_cmd_e cmd
);

    logic cke_q;

    // Remember clock enable of the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q <= 1'b1;
        end else begin
            cke_q <= cke;
        end
    end

    // Map the pin pattern to a command code.
    always_comb begin
        cmd = CMD_NOP;
        if (!cke_q) begin
            cmd = CMD_HOLD;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b000:  cmd = CMD_MODE;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                3'b010:  cmd = a10 ? CMD_PREALL : CMD_PRE;
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = CMD_WRITE;
                3'b101:  cmd = CMD_READ;
                3'b110:  cmd = CMD_BSTOP;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdcm_bank_track.sv
// Per-bank open-row tracker.
// One flag per bank, set by an activate to that bank, cleared by a
// single-bank precharge to it or by an all-bank precharge. Assumes cmd is
// the decoded command of the current edge.
module sdcm_bank_track
    import sdcm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  sdcm_cmd_e            cmd,
    input  logic [BA_W-1:0]      ba,
    output logic [NUM_BANKS-1:0] open_o
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Update the open flag of bank b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_o[b] <= 1'b0;
            end else begin
                unique case (cmd)
                    CMD_ACT:    if (ba == BA_W'(b)) open_o[b] <= 1'b1;
                    CMD_PRE:    if (ba == BA_W'(b)) open_o[b] <= 1'b0;
                    CMD_PREALL: open_o[b] <= 1'b0;
                    default:    open_o[b] <= open_o[b];
                endcase
            end
        end
    end

    // R5: an all-bank precharge leaves no bank open.
    a_r5_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PREALL) |=> (open_o == '0));

    // R4: an activate leaves its bank open.
    a_r4_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |=> open_o[$past(ba)]);

    // R2: deselect and held-clock cycles change no bank.
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_DESEL || cmd == CMD_HOLD) |=> $stable(open_o));

endmodule

// File: rtl/sdcm_rrd_timer.sv
// Activate-to-activate spacing timer.
// Counts edges since the last activate, saturating at TRRD. It flags an
// activate to a bank other than the last activated one that comes early.
// Assumes TRRD >= 1.
module sdcm_rrd_timer
    import sdcm_pkg::*;
#(
    parameter int TRRD = 2,
    parameter int BA_W = 2,
    localparam int GW = $clog2(TRRD + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  sdcm_cmd_e       cmd,
    input  logic [BA_W-1:0] ba,
    output logic            too_soon
);

    logic [GW-1:0]   gap_q;
    logic [BA_W-1:0] last_q;
    logic            is_act;

    assign is_act = (cmd == CMD_ACT);

    // Track the edge count and bank of the most recent activate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= GW'(TRRD);
            last_q <= '0;
        end else if (is_act) begin
            gap_q  <= GW'(1);
            last_q <= ba;
        end else if (gap_q < GW'(TRRD)) begin
            gap_q  <= gap_q + GW'(1);
        end
    end

    // Early activate to another bank.
    always_comb begin
        too_soon = is_act && (gap_q < GW'(TRRD)) && (ba != last_q);
    end

    // R9: the spacing counter never passes its limit.
    a_r9_gap_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q <= GW'(TRRD)));

endmodule

// File: rtl/sdram_cmd_monitor.sv
// SDRAM command monitor top.
// Decodes the bus command, tracks open banks and registers an error code
// for bank-protocol violations. Pure observer: drives nothing on the bus.
// Assumes NUM_BANKS is a power of two and TRRD >= 1.
module sdram_cmd_monitor
    import sdcm_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TRRD      = 2,
    localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic                 a10,
    output logic [3:0]           cmd_o,
    output logic [NUM_BANKS-1:0] bank_open_o,
    output logic                 err_o,
    output logic [2:0]           err_code_o
);

    sdcm_cmd_e cmd_now;
    sdcm_err_e err_next;
    sdcm_err_e err_q;
    sdcm_cmd_e cmd_q;
    logic      early_act;

    sdcm_decode i_decode (
        .clk   (clk),
        .rst_n (rst_n),
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (a10),
        .cmd   (cmd_now)
    );

    sdcm_bank_track #(.NUM_BANKS(NUM_BANKS)) i_banks (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd_now),
        .ba     (ba),
        .open_o (bank_open_o)
    );

    sdcm_rrd_timer #(.TRRD(TRRD), .BA_W(BA_W)) i_rrd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd_now),
        .ba       (ba),
        .too_soon (early_act)
    );

    // Classify the current command against the bank state before it.
    always_comb begin
        err_next = ERR_NONE;
        unique case (cmd_now)
            CMD_READ, CMD_WRITE: begin
                if (!bank_open_o[ba]) err_next = ERR_IDLE_BANK;
            end
            CMD_ACT: begin
                if (bank_open_o[ba])  err_next = ERR_REOPEN;
                else if (early_act)   err_next = ERR_ACT_SPACE;
            end
            CMD_AREF, CMD_SREF: begin
                if (|bank_open_o)     err_next = ERR_REF_OPEN;
            end
            CMD_MODE: begin
                if (|bank_open_o)     err_next = ERR_MODE_OPEN;
            end
            default: err_next = ERR_NONE;
        endcase
    end

    // Register the reported command and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_DESEL;
            err_q <= ERR_NONE;
        end else begin
            cmd_q <= cmd_now;
            err_q <= err_next;
        end
    end

    assign cmd_o      = cmd_q;
    assign err_code_o = err_q;
    assign err_o      = (err_q != ERR_NONE);

    // R7: an idle-bank error is only reported against a read or a write.
    a_r7_idle_is_access: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code_o == 3'(ERR_IDLE_BANK)) |->
            (cmd_o == 4'(CMD_READ) || cmd_o == 4'(CMD_WRITE)));

    // R8: a reopen error leaves the bank open.
    a_r8_reopen_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code_o == 3'(ERR_REOPEN)) |-> (cmd_o == 4'(CMD_ACT)) && (bank_open_o != '0));

    // R10: a refresh error means some bank was and still is open.
    a_r10_ref_open: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code_o == 3'(ERR_REF_OPEN)) |-> (bank_open_o != '0));

    // R11: no error code follows a held-clock or deselect cycle.
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'(CMD_HOLD) || cmd_o == 4'(CMD_DESEL)) |-> !err_o);

endmodule

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 4;
    localparam int TRRD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [1:0] ba = 2'd0;
    logic [3:0] cmd_o;
    logic [NB-1:0] bank_open_o;
    logic       err_o;
    logic [2:0] err_code_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_cmd_monitor #(.NUM_BANKS(NB), .TRRD(TRRD)) i_sdram_cmd_monitor (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
        .cmd_o(cmd_o), .bank_open_o(bank_open_o), .err_o(err_o), .err_code_o(err_code_o)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Drive one edge's pins, then sample just after that edge.
    task automatic pins(input logic k, input logic c, input logic r, input logic ca,
                        input logic w, input logic [1:0] b, input logic a);
        @(negedge clk);
        cke = k; cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; a10 = a;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();              pins(1, 0, 1, 1, 1, 0, 0); endtask
    task automatic act(input int b);   pins(1, 0, 0, 1, 1, 2'(b), 0); endtask
    task automatic prea();             pins(1, 0, 0, 1, 0, 0, 1); endtask

    task automatic t_reset();
        chk("R1 cmd", cmd_o, 0);
        chk("R1 open", bank_open_o, 0);
        chk("R1 err", err_o, 0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 code", err_code_o, 0);
    endtask

    task automatic t_decode();
        nop();                   chk("R3 nop", cmd_o, 1);
        pins(1,0,0,0,0,0,0);     chk("R3 mode", cmd_o, 2); chk("R3 mode no err", err_code_o, 0);
        pins(1,0,1,1,0,0,0);     chk("R3 burst stop", cmd_o, 8);
        pins(1,1,0,0,0,0,1);     chk("R2 deselect", cmd_o, 0);
    endtask

    task automatic t_act_pre();
        act(2);                  chk("R4 act cmd", cmd_o, 3); chk("R4 open b2", bank_open_o, 4'b0100);
        nop(); nop(); nop();
        act(0);                  chk("R4 open b0", bank_open_o, 4'b0101); chk("R9 spaced ok", err_code_o, 0);
        nop(); nop(); nop();
        pins(1,0,1,0,1,2,0);     chk("R3 read", cmd_o, 4); chk("R7 read open ok", err_code_o, 0);
        pins(1,0,1,0,0,0,0);     chk("R3 write", cmd_o, 5);
        pins(1,0,0,1,0,2,0);     chk("R5 pre cmd", cmd_o, 6); chk("R5 pre one", bank_open_o, 4'b0001);
        act(1);                  chk("R4 open b1", bank_open_o, 4'b0011);
        prea();                  chk("R5 preall cmd", cmd_o, 7); chk("R5 preall", bank_open_o, 0);
    endtask

    task automatic t_desel();
        nop(); nop(); nop();
        act(3);                  chk("R4 open b3", bank_open_o, 4'b1000);
        pins(1,1,0,1,0,3,1);     chk("R2 desel code", cmd_o, 0);
        chk("R2 desel keeps bank", bank_open_o, 4'b1000); chk("R2 desel no err", err_o, 0);
        prea();
    endtask

    task automatic t_errors();
        nop(); nop(); nop();
        pins(1,0,1,0,1,1,0);     chk("R7 read idle", err_code_o, 1); chk("R11 err high", err_o, 1);
        pins(1,0,1,0,0,3,0);     chk("R7 write idle", err_code_o, 1);
        nop();                   chk("R11 err clears", err_o, 0); chk("R11 code clears", err_code_o, 0);
        act(0); nop(); nop(); nop();
        act(0);                  chk("R8 reopen", err_code_o, 2); chk("R8 still open", bank_open_o, 4'b0001);
        act(1);                  chk("R9 early act", err_code_o, 3); chk("R9 bank opened", bank_open_o, 4'b0011);
        nop();
        pins(1,0,0,0,1,0,0);     chk("R10 aref open", err_code_o, 4); chk("R6 aref code", cmd_o, 9);
        pins(1,0,0,0,0,0,0);     chk("R10 mode open", err_code_o, 5);
        prea(); nop(); nop(); nop();
        act(2); nop(); nop();
        act(3);                  chk("R9 boundary ok", err_code_o, 0); chk("R9 both open", bank_open_o, 4'b1100);
        prea();
    endtask

    task automatic t_refresh();
        pins(1,0,0,0,1,0,0);     chk("R6 aref", cmd_o, 9); chk("R6 aref idle ok", err_code_o, 0);
        pins(0,0,0,0,1,0,0);     chk("R6 sref entry", cmd_o, 10); chk("R6 sref idle ok", err_o, 0);
        pins(0,1,1,1,1,0,0);     chk("R6 held", cmd_o, 11);
        pins(0,0,0,1,1,0,0);     chk("R6 held act code", cmd_o, 11); chk("R6 held no open", bank_open_o, 0);
        pins(1,0,1,1,1,0,0);     chk("R6 exit edge held", cmd_o, 11);
        nop();                   chk("R6 back to nop", cmd_o, 1);
        nop(); nop();
        act(0); nop(); nop(); nop();
        pins(0,0,0,0,1,0,0);     chk("R10 sref open", err_code_o, 4); chk("R6 sref code", cmd_o, 10);
        pins(1,1,1,1,1,0,0);
        nop();
        prea();                  chk("R5 final close", bank_open_o, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_decode();
        t_act_pre();
        t_desel();
        t_errors();
        t_refresh();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule